// File: doc/BRIEF.md
# Configuration Memory Scrubber

This block walks a row-organised configuration memory in the background and repairs single-bit upsets in place. A pass visits every row in ascending order. For each row it reads every word and folds it into a signature, then fetches that row's stored reference signature and compares the two. If they differ and the difference points to exactly one bit, the block reads that word, inverts the bit and writes the word back. It then scans the row a second time to confirm that the repair held. A difference that does not point to one bit, or that survives the repair, sets a sticky uncorrectable flag.

A pass starts only while the scrub enable and the configuration-done input are both high, and only after a programmable number of idle cycles. Each row keeps a saturating count of the repairs made in it, and a wider output gives the sum of all the row counts. Host logic supplies the memory and the reference-signature store. Both are read with a fixed latency of one cycle.

The signature of a row has two parts. The first is the XOR, over every set bit, of a code equal to `word_index * WORD_W + bit_index + 1`. The second is a parity bit over all the bits. Because of this, the difference between the computed and the reference signature directly gives the position of a single flipped bit.

Top module: `cfg_scrubber`

## Requirements
- R1: While `rst_n` is low and right after it is released, `busy`, `mem_rd`, `mem_wr`, `fix_pulse` and `uncorr_flag` are 0, and every row counter and `corr_sum` are 0.
- R2: A pass starts only while `scrub_en` and `cfg_done` are both 1. The pass begins (`busy` rises) after `interval`+1 consecutive qualifying idle cycles. Dropping `scrub_en` during a pass does not abort it.
- R3: During a clean pass, the block reads each word of each row exactly once. Addresses are `{row, word}`, with the row in bits [5:3] and the word in bits [2:0], and the reads run in ascending order. `busy` stays high for `NUM_ROWS*(WORDS+2)` cycles (50 with the default parameters). No memory access happens while `busy` is 0, and a read and a write never occur in the same cycle.
- R4: The signature is 9 bits. Bit 8 is the parity of all 128 bits of the row. Bits [7:0] are the XOR of `w*16+b+1` over every set bit b of word w.
- R5: When the signature difference has parity 1 and a syndrome s in 1..128, the block repairs the fault. It reads word (s-1)/16 of that row, and in the next cycle writes the same address with bit (s-1)%16 inverted. Exactly one write is made.
- R6: Each repair adds one to the 8-bit counter of its row. The counter stays at 255 once it reaches it.
- R7: `corr_sum` (11 bits) always equals the sum of the five row counters.
- R8: After a repair, the row is scanned once more. If a mismatch remains, `uncorr_flag` is set and no further write is made in that pass.
- R9: A nonzero difference is uncorrectable when its parity is 0, its syndrome is 0, or its syndrome is above 128. In that case `uncorr_flag` is set, no write is made, and the counters stay unchanged.
- R10: `uncorr_flag` stays set until reset.
- R11: A row whose signature matches its reference causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scrub_en | input | 1 | Allows passes to start |
| cfg_done | input | 1 | Initial configuration has finished |
| interval | input | 16 | Idle cycles between passes, minus one |
| mem_rd | output | 1 | Memory read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 6 | Word address `{row, word}` |
| mem_wdata | output | 16 | Repaired word |
| mem_rdata | input | 16 | Read data |
| ref_rd | output | 1 | Reference read strobe; data is returned one cycle later |
| ref_row | output | 3 | Row whose reference is requested |
| ref_sig | input | 9 | Reference signature |
| busy | output | 1 | A pass is running |
| fix_pulse | output | 1 | High in the cycle a repaired word is written |
| uncorr_flag | output | 1 | Sticky uncorrectable-mismatch flag |
| row_cnt | output | 40 | Row counters; row r occupies bits [8r+7:8r] |
| corr_sum | output | 11 | Sum of the row counters |

## Verification
A wrong syndrome accumulation or a wrong decode shows up within one pass. The bit that gets written back is the wrong one, so the word is still corrupt and the recheck raises `uncorr_flag`. A miscounted scan index or row register shows up as out-of-order read addresses and a `busy` window of the wrong length on the very first clean pass. A counter that wraps instead of saturating, or a faulty sum, shows up once a row has seen its 256th repair. The sweep flips every bit of every row twice in order to reach that point.

// File: rtl/cfg_scrub_pkg.sv
package cfg_scrub_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DRAIN,
    ST_CMP,
    ST_FIX_RD,
    ST_FIX_WR
  } scrub_state_e;

  // Position code of one bit inside a row: never zero
  function automatic int bit_code(int word_idx, int bit_idx, int word_w);
    return word_idx * word_w + bit_idx + 1;
  endfunction

endpackage

// File: rtl/cfg_scrub_sig.sv
module cfg_scrub_sig
  import cfg_scrub_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WRD_W  = 3,
  parameter int SIG_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              data_vld,
  input  logic [WRD_W-1:0]  data_idx,
  input  logic [WORD_W-1:0] data,
  input  logic              ref_vld,
  input  logic [SIG_W-1:0]  ref_in,
  output logic [SIG_W-1:0]  diff
);
  localparam int SYN_W = SIG_W - 1;

  logic [SIG_W-1:0] acc_q;
  logic [SIG_W-1:0] ref_q;

  // Contribution of one word: XOR of position codes plus parity
  function automatic logic [SIG_W-1:0] word_contrib(logic [WORD_W-1:0] d,
                                                    logic [WRD_W-1:0] w);
    logic [SIG_W-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (d[b]) begin
        r[SYN_W-1:0] = r[SYN_W-1:0] ^ SYN_W'(bit_code(int'(w), b, WORD_W));
        r[SYN_W]     = ~r[SYN_W];
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ref_q <= '0;
    end else begin
      if (clear)         acc_q <= '0;
      else if (data_vld) acc_q <= acc_q ^ word_contrib(data, data_idx);
      if (ref_vld)       ref_q <= ref_in;
    end
  end

  assign diff = acc_q ^ ref_q;

endmodule

// File: rtl/cfg_scrub_cnt.sv
module cfg_scrub_cnt #(
  parameter int NUM_ROWS = 5,
  parameter int CNT_W    = 8,
  parameter int ROW_W    = 3,
  parameter int SUM_W    = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inc,
  input  logic [ROW_W-1:0]          inc_row,
  output logic [NUM_ROWS*CNT_W-1:0] cnt_flat,
  output logic [SUM_W-1:0]          sum
);

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    logic [CNT_W-1:0] cnt_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_r <= '0;
      end else if (inc && inc_row == ROW_W'(g) && cnt_r != '1) begin
        cnt_r <= cnt_r + 1'b1;
      end
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_r;
  end

  always_comb begin
    sum = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      sum = sum + SUM_W'(cnt_flat[r*CNT_W +: CNT_W]);
    end
  end

endmodule

// File: rtl/cfg_scrub_ctrl.sv
module cfg_scrub_ctrl
  import cfg_scrub_pkg::*;
#(
  parameter int NUM_ROWS = 5,
  parameter int WORDS    = 8,
  parameter int WORD_W   = 16,
  parameter int TMR_W    = 16,
  parameter int ROW_W    = 3,
  parameter int WRD_W    = 3,
  parameter int BIT_W    = 4,
  parameter int SIG_W    = 9,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_en,
  input  logic              cfg_done,
  input  logic [TMR_W-1:0]  interval,
  input  logic [SIG_W-1:0]  diff,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ref_rd,
  output logic [ROW_W-1:0]  ref_row,
  output logic              acc_clear,
  output logic              scan_vld_q,
  output logic [WRD_W-1:0]  scan_idx_q,
  output logic              ref_vld_q,
  output logic              busy,
  output logic              start_evt,
  output logic              fix_evt,
  output logic              uncorr_evt,
  output logic [ROW_W-1:0]  fix_row
);
  localparam int SYN_W = SIG_W - 1;
  localparam int BITS  = WORDS * WORD_W;

  scrub_state_e     state;
  logic [ROW_W-1:0] row;
  logic [WRD_W-1:0] word;
  logic [TMR_W-1:0] timer;
  logic             recheck;
  logic [WRD_W-1:0] bad_word;
  logic [BIT_W-1:0] bad_bit;

  logic             mismatch;
  logic             fixable;
  logic [WRD_W-1:0] loc_word;
  logic [BIT_W-1:0] loc_bit;
  logic             last_word;
  logic             last_row;

  // Single-bit decode of a signature difference
  function automatic logic diff_fixable(logic [SIG_W-1:0] d);
    int s;
    s = int'(d[SYN_W-1:0]);
    return d[SYN_W] && (s != 0) && (s <= BITS);
  endfunction

  function automatic int diff_index(logic [SIG_W-1:0] d);
    return int'(d[SYN_W-1:0]) - 1;
  endfunction

  always_comb begin
    mismatch  = (diff != '0);
    fixable   = diff_fixable(diff);
    loc_word  = WRD_W'(diff_index(diff) / WORD_W);
    loc_bit   = BIT_W'(diff_index(diff) % WORD_W);
    last_word = (word == WRD_W'(WORDS - 1));
    last_row  = (row == ROW_W'(NUM_ROWS - 1));
  end

  assign start_evt  = (state == ST_IDLE) && scrub_en && cfg_done && (timer >= interval);
  assign fix_evt    = (state == ST_FIX_WR);
  assign uncorr_evt = (state == ST_CMP) && mismatch && !(fixable && !recheck);
  assign acc_clear  = start_evt || (state == ST_CMP) || (state == ST_FIX_WR);

  assign busy      = (state != ST_IDLE);
  assign mem_rd    = (state == ST_SCAN) || (state == ST_FIX_RD);
  assign mem_wr    = fix_evt;
  assign mem_addr  = (state == ST_SCAN) ? {row, word} : {row, bad_word};
  assign mem_wdata = mem_rdata ^ (WORD_W'(1) << bad_bit);
  assign ref_rd    = (state == ST_SCAN) && (word == '0);
  assign ref_row   = row;
  assign fix_row   = row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      row        <= '0;
      word       <= '0;
      timer      <= '0;
      recheck    <= 1'b0;
      bad_word   <= '0;
      bad_bit    <= '0;
      scan_vld_q <= 1'b0;
      scan_idx_q <= '0;
      ref_vld_q  <= 1'b0;
    end else begin
      scan_vld_q <= (state == ST_SCAN);
      scan_idx_q <= word;
      ref_vld_q  <= ref_rd;
      unique case (state)
        ST_IDLE: begin
          if (scrub_en && cfg_done) begin
            if (timer >= interval) begin
              state   <= ST_SCAN;
              row     <= '0;
              word    <= '0;
              recheck <= 1'b0;
              timer   <= '0;
            end else begin
              timer <= timer + 1'b1;
            end
          end else begin
            timer <= '0;
          end
        end
        ST_SCAN: begin
          if (last_word) begin
            word  <= '0;
            state <= ST_DRAIN;
          end else begin
            word <= word + 1'b1;
          end
        end
        ST_DRAIN: state <= ST_CMP;
        ST_CMP: begin
          if (mismatch && fixable && !recheck) begin
            bad_word <= loc_word;
            bad_bit  <= loc_bit;
            state    <= ST_FIX_RD;
          end else begin
            recheck <= 1'b0;
            word    <= '0;
            if (last_row) begin
              state <= ST_IDLE;
            end else begin
              row   <= row + 1'b1;
              state <= ST_SCAN;
            end
          end
        end
        ST_FIX_RD: state <= ST_FIX_WR;
        ST_FIX_WR: begin
          recheck <= 1'b1;
          word    <= '0;
          state   <= ST_SCAN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
  parameter int NUM_ROWS = 5,
  parameter int WORDS    = 8,
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 8,
  parameter int TMR_W    = 16,
  parameter int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  parameter int WRD_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  parameter int BIT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  parameter int SIG_W    = $clog2(WORDS * WORD_W + 1) + 1,
  parameter int ADDR_W   = ROW_W + WRD_W,
  parameter int SUM_W    = CNT_W + ((NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scrub_en,
  input  logic                      cfg_done,
  input  logic [TMR_W-1:0]          interval,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]         mem_wdata,
  input  logic [WORD_W-1:0]         mem_rdata,
  output logic                      ref_rd,
  output logic [ROW_W-1:0]          ref_row,
  input  logic [SIG_W-1:0]          ref_sig,
  output logic                      busy,
  output logic                      fix_pulse,
  output logic                      uncorr_flag,
  output logic [NUM_ROWS*CNT_W-1:0] row_cnt,
  output logic [SUM_W-1:0]          corr_sum
);

  logic [SIG_W-1:0] diff;
  logic             acc_clear;
  logic             scan_vld_q;
  logic [WRD_W-1:0] scan_idx_q;
  logic             ref_vld_q;
  logic             start_evt;
  logic             fix_evt;
  logic             uncorr_evt;
  logic [ROW_W-1:0] fix_row;

  cfg_scrub_ctrl #(
    .NUM_ROWS(NUM_ROWS), .WORDS(WORDS), .WORD_W(WORD_W), .TMR_W(TMR_W),
    .ROW_W(ROW_W), .WRD_W(WRD_W), .BIT_W(BIT_W), .SIG_W(SIG_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scrub_en   (scrub_en),
    .cfg_done   (cfg_done),
    .interval   (interval),
    .diff       (diff),
    .mem_rdata  (mem_rdata),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .ref_rd     (ref_rd),
    .ref_row    (ref_row),
    .acc_clear  (acc_clear),
    .scan_vld_q (scan_vld_q),
    .scan_idx_q (scan_idx_q),
    .ref_vld_q  (ref_vld_q),
    .busy       (busy),
    .start_evt  (start_evt),
    .fix_evt    (fix_evt),
    .uncorr_evt (uncorr_evt),
    .fix_row    (fix_row)
  );

  cfg_scrub_sig #(
    .WORD_W(WORD_W), .WRD_W(WRD_W), .SIG_W(SIG_W)
  ) u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (acc_clear),
    .data_vld (scan_vld_q),
    .data_idx (scan_idx_q),
    .data     (mem_rdata),
    .ref_vld  (ref_vld_q),
    .ref_in   (ref_sig),
    .diff     (diff)
  );

  cfg_scrub_cnt #(
    .NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W), .ROW_W(ROW_W), .SUM_W(SUM_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (fix_evt),
    .inc_row  (fix_row),
    .cnt_flat (row_cnt),
    .sum      (corr_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          uncorr_flag <= 1'b0;
    else if (uncorr_evt) uncorr_flag <= 1'b1;
  end

  assign fix_pulse = fix_evt;

endmodule

// File: rtl/cfg_scrubber_chk.sv
module cfg_scrubber_chk #(
  parameter int ADDR_W = 6,
  parameter int SUM_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scrub_en,
  input logic              cfg_done,
  input logic              busy,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fix_pulse,
  input logic              uncorr_flag,
  input logic              uncorr_evt,
  input logic [SUM_W-1:0]  corr_sum
);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(scrub_en && cfg_done));

  assert_rmw_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

  assert_recheck_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fix_pulse |=> (busy && mem_rd && !mem_wr));

  assert_sum_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_sum != $past(corr_sum)) |-> $past(fix_pulse));

  assert_sum_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    corr_sum >= $past(corr_sum));

  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uncorr_flag) |-> $past(uncorr_evt));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr_flag |=> uncorr_flag);

endmodule

bind cfg_scrubber cfg_scrubber_chk #(.ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scrub_en    (scrub_en),
  .cfg_done    (cfg_done),
  .busy        (busy),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_addr    (mem_addr),
  .fix_pulse   (fix_pulse),
  .uncorr_flag (uncorr_flag),
  .uncorr_evt  (uncorr_evt),
  .corr_sum    (corr_sum)
);

// File: tb/cfg_scrubber_tb.sv
`timescale 1ns/1ps
module cfg_scrubber_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scrub_en = 1'b0;
  logic        cfg_done = 1'b0;
  logic [15:0] interval = 16'd2;
  logic        mem_rd, mem_wr, ref_rd, busy, fix_pulse, uncorr_flag;
  logic [5:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [2:0]  ref_row;
  logic [8:0]  ref_sig = '0;
  logic [39:0] row_cnt;
  logic [10:0] corr_sum;

  int vectors = 0;
  int fails = 0;

  logic [15:0] mem  [64];
  logic [15:0] gold [64];
  logic [8:0]  refs [8];
  int          wr_count = 0;
  logic        stuck_en = 1'b0;
  logic [5:0]  stuck_addr = '0;
  logic        log_en = 1'b0;
  int          rd_log [64];
  int          rd_n = 0;

  always #2.5 clk = ~clk;

  cfg_scrubber u_dut (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .cfg_done(cfg_done),
    .interval(interval), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ref_rd(ref_rd),
    .ref_row(ref_row), .ref_sig(ref_sig), .busy(busy), .fix_pulse(fix_pulse),
    .uncorr_flag(uncorr_flag), .row_cnt(row_cnt), .corr_sum(corr_sum)
  );

  // Memory and reference store, one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (ref_rd) ref_sig <= refs[ref_row];
    if (mem_wr) begin
      wr_count = wr_count + 1;
      if (!(stuck_en && mem_addr == stuck_addr)) mem[mem_addr] <= mem_wdata;
    end
    if (log_en && mem_rd && rd_n < 64) begin
      rd_log[rd_n] = int'(mem_addr);
      rd_n = rd_n + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R4 signature restated: walk flat bit positions of the row
  function automatic logic [8:0] calc_sig(int r);
    logic [7:0] s;
    logic p;
    s = '0;
    p = 1'b0;
    for (int i = 0; i < 128; i++) begin
      if (gold[r*8 + i/16][i%16]) begin
        s = s ^ 8'(i + 1);
        p = ~p;
      end
    end
    return {p, s};
  endfunction

  function automatic int cnt_of(int r);
    return int'(row_cnt[r*8 +: 8]);
  endfunction

  task automatic do_reset();
    scrub_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_pass();
    @(negedge clk);
    scrub_en = 1'b1;
    while (!busy) @(negedge clk);
    scrub_en = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int exp_cnt [5];
    int first, bcount, w0;
    logic order_ok, quiet;

    for (int a = 0; a < 64; a++) begin
      gold[a] = 16'((a * 40503) ^ 16'h5A3C);
      mem[a]  = gold[a];
    end
    for (int r = 0; r < 8; r++) refs[r] = (r < 5) ? calc_sig(r) : 9'd0;

    // R1 reset state, during and after reset
    repeat (2) @(negedge clk);
    check(!busy && !mem_rd && !mem_wr && !fix_pulse, "R1 busy/strobes in reset", int'(busy), 0);
    check(row_cnt == '0 && corr_sum == '0, "R1 counters in reset", int'(corr_sum), 0);
    check(!uncorr_flag, "R1 flag in reset", int'(uncorr_flag), 0);
    do_reset();
    check(!busy && !uncorr_flag && corr_sum == '0, "R1 after release", int'(busy), 0);

    // R2 gating: enable without cfg_done, then cfg_done without enable
    quiet = 1'b1;
    scrub_en = 1'b1; cfg_done = 1'b0;
    repeat (40) begin @(negedge clk); if (busy || mem_rd) quiet = 1'b0; end
    scrub_en = 1'b0; cfg_done = 1'b1;
    repeat (40) begin @(negedge clk); if (busy || mem_rd) quiet = 1'b0; end
    check(quiet, "R2 no pass without both enables", int'(!quiet), 0);

    // R2 start timing, R3 read order and busy length, R11 no write on clean pass
    interval = 16'd6;
    log_en = 1'b1; rd_n = 0; w0 = wr_count;
    first = 0;
    scrub_en = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (busy && first == 0) first = k;
      if (first != 0) break;
    end
    scrub_en = 1'b0;
    check(first == 7, "R2 start after interval+1 cycles", first, 7);
    bcount = 1;
    while (busy) begin @(negedge clk); if (busy) bcount++; end
    log_en = 1'b0;
    check(bcount == 50, "R3 busy length of clean pass", bcount, 50);
    check(rd_n == 40, "R3/R2 read count (pass not aborted)", rd_n, 40);
    order_ok = 1'b1;
    for (int i = 0; i < 40; i++) if (rd_log[i] != i) order_ok = 1'b0;
    check(order_ok, "R3 ascending read order", int'(order_ok), 1);
    check(wr_count == w0, "R11 clean pass writes", wr_count - w0, 0);

    // R4 R5 R6 R7 sweep: every bit of every row, twice
    interval = 16'd2;
    for (int r = 0; r < 5; r++) exp_cnt[r] = 0;
    for (int rnd = 0; rnd < 2; rnd++) begin
      for (int r = 0; r < 5; r++) begin
        for (int i = 0; i < 128; i++) begin
          int a;
          a = r*8 + i/16;
          mem[a][i%16] = ~mem[a][i%16];
          w0 = wr_count;
          run_pass();
          if (exp_cnt[r] < 255) exp_cnt[r]++;
          check(mem[a] == gold[a], "R5 word repaired", int'(mem[a]), int'(gold[a]));
          check(wr_count - w0 == 1, "R5 single write", wr_count - w0, 1);
          check(cnt_of(r) == exp_cnt[r], "R6 row counter", cnt_of(r), exp_cnt[r]);
          check(int'(corr_sum) == exp_cnt[0]+exp_cnt[1]+exp_cnt[2]+exp_cnt[3]+exp_cnt[4],
                "R7 summed count", int'(corr_sum),
                exp_cnt[0]+exp_cnt[1]+exp_cnt[2]+exp_cnt[3]+exp_cnt[4]);
          check(!uncorr_flag, "R4 no false uncorrectable", int'(uncorr_flag), 0);
        end
      end
    end
    for (int r = 0; r < 5; r++) check(cnt_of(r) == 255, "R6 saturation at 255", cnt_of(r), 255);
    check(corr_sum == 11'd1275, "R7 saturated sum", int'(corr_sum), 1275);

    // R9 double error in one row: parity even
    mem[17][3] = ~mem[17][3];
    mem[20][9] = ~mem[20][9];
    w0 = wr_count;
    run_pass();
    check(uncorr_flag, "R9 double error flagged", int'(uncorr_flag), 1);
    check(wr_count == w0, "R9 no write on double error", wr_count - w0, 0);
    check(corr_sum == 11'd1275, "R9 counters unchanged", int'(corr_sum), 1275);
    check(mem[17] != gold[17], "R9 memory left untouched", int'(mem[17]), int'(gold[17] ^ 16'h0008));
    mem[17] = gold[17]; mem[20] = gold[20];
    run_pass();
    check(uncorr_flag, "R10 flag sticky over clean pass", int'(uncorr_flag), 1);

    // R9 odd parity, syndrome out of range (200 > 128)
    do_reset();
    refs[3] = calc_sig(3) ^ {1'b1, 8'd200};
    w0 = wr_count;
    run_pass();
    check(uncorr_flag && wr_count == w0, "R9 syndrome above range", wr_count - w0, 0);
    refs[3] = calc_sig(3);

    // R9 odd parity, zero syndrome
    do_reset();
    refs[1] = calc_sig(1) ^ 9'h100;
    w0 = wr_count;
    run_pass();
    check(uncorr_flag && wr_count == w0, "R9 zero syndrome odd parity", int'(uncorr_flag), 1);
    refs[1] = calc_sig(1);

    // R8 repair that does not stick
    do_reset();
    stuck_en = 1'b1; stuck_addr = 6'd37;
    mem[37][0] = ~mem[37][0];
    w0 = wr_count;
    run_pass();
    check(wr_count - w0 == 1, "R8 one write then no retry", wr_count - w0, 1);
    check(cnt_of(4) == 1, "R8 repair counted", cnt_of(4), 1);
    check(uncorr_flag, "R8 persisting mismatch flagged", int'(uncorr_flag), 1);
    stuck_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule